// File: doc/BRIEF.md
# Serial Flash Continuous-Read Host Engine

This block sits on the host side of a serial NOR flash link. It streams an arbitrary number of bytes out of the flash array with a single continuous-read command. A request carries a page number, a byte offset inside that page, a byte count, a flag that selects the 264-byte or the 256-byte page layout, and a flag that selects the fast or the slow read command. The engine lowers chip select, shifts out the command header, then clocks in data bytes. It hands each byte to a valid/ready stream and raises chip select once the last byte has been sampled.

The flash advances its internal address by itself. It moves from one page into the next, and from the end of the array back to its start, with no extra command. The engine therefore issues one header per request, however many page boundaries the byte count spans.

When the consumer stops accepting bytes, the serial clock halts with chip select still low, and the read picks up where it stopped. The serial clock runs at a fast rate or at half that rate, depending on the command chosen.

Top module: `sflash_cont_reader`

## Requirements
- R1: A fast request sends opcode 0x0B, then three address bytes, then one dummy byte, all MSB first, before the first data bit is sampled.
- R2: A slow request sends opcode 0x03, then three address bytes, with no dummy byte before the data.
- R3: In 264-byte layout the 24-bit address is three zero bits, then the 12-bit page number, then the 9-bit offset (offset in bits 8..0, page in bits 20..9).
- R4: In 256-byte layout the 24-bit address is four zero bits, then the 12-bit page number, then offset bits 7..0; offset bit 8 is ignored.
- R5: Chip select falls exactly once per request and stays low through the last data bit. This holds across page boundaries and across the wrap from the end of the array to its start.
- R6: SPI mode 0: SCK is low whenever chip select is high, MOSI changes only while SCK is low, and MISO is sampled at the rising SCK edge.
- R7: Each SCK high phase lasts FAST_HALF clock cycles for a fast request and 2*FAST_HALF cycles for a slow request.
- R8: Data bytes appear on outData in array order, one per outValid/outReady handshake. outData and outValid hold while outReady is low, and the serial clock stops so that no byte is lost.
- R9: done is a single-cycle pulse raised only after the last byte has been accepted and chip select is high. startReady is high only while the engine is idle.
- R10: Between two requests, chip select stays high for at least one full SCK period of the earlier request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Request strobe, taken when startReady is high |
| startReady | output | 1 | Engine idle, able to take a request |
| reqPage | input | PAGE_W | Page number |
| reqOffset | input | OFF_W | Byte offset in the page |
| reqCount | input | CNT_W | Number of bytes to read, at least 1 |
| reqPage264 | input | 1 | 1: 264-byte page layout, 0: 256-byte layout |
| reqFast | input | 1 | 1: fast command with dummy byte, 0: slow command |
| csN | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| outData | output | 8 | Received byte |
| outValid | output | 1 | outData holds a byte |
| outReady | input | 1 | Consumer accepts the byte |
| done | output | 1 | Request finished pulse |

## Verification
The properties assume that the request fields are stable in the cycle startValid is sampled and that reqCount is never zero. They also assume the consumer never takes back a byte it has not yet accepted. The bench raises startValid for exactly one cycle, only after it has seen startReady, and issues only non-zero counts. A bus-functional flash model decodes the header and serves bytes from a computed array. The consumer's ready line is driven always high, pseudo-randomly, or with long stalls, so the clock-pause path is exercised without breaking those assumptions.

// File: rtl/sflash_rd_pkg.sv
package sflash_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_GAP
  } state_t;

  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic shiftTx;
    logic sample;
    logic present;
    logic csRelease;
  } strobe_t;

  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_SLOW = 8'h03;
  localparam int HDR_FAST = 40;
  localparam int HDR_SLOW = 32;
  localparam int FRAME_W = 40;

endpackage

// File: rtl/sflash_rd_ctrl.sv
module sflash_rd_ctrl
  import sflash_rd_pkg::*;
#(
  parameter int FAST_HALF = 1,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             reqFast,
  input  logic             sckLvl,
  input  logic             outValid,
  output logic             startReady,
  output logic             done,
  output strobe_t          stb
);
  localparam int SLOW_HALF = 2 * FAST_HALF;
  localparam int DIV_W = $clog2(2 * SLOW_HALF + 1);

  state_t           state;
  logic             fastMode;
  logic [DIV_W-1:0] divCnt;
  logic [5:0]       preLeft;
  logic [2:0]       dataBit;
  logic [CNT_W-1:0] bytesLeft;
  logic [DIV_W-1:0] curHalf;
  logic [DIV_W-1:0] gapEnd;
  logic             inPre;
  logic             stall;
  logic             tick;

  assign curHalf = fastMode ? DIV_W'(FAST_HALF) : DIV_W'(SLOW_HALF);
  assign gapEnd = DIV_W'(2) * curHalf - DIV_W'(1);
  assign inPre = (preLeft != 6'd0);
  assign startReady = (state == ST_IDLE);

  // the byte-completing rising edge waits while the previous byte is unaccepted
  assign stall = (state == ST_RUN) && !sckLvl && !inPre && (dataBit == 3'd7) && outValid;
  assign tick = (state == ST_RUN) && !stall && (divCnt == curHalf - DIV_W'(1));

  always_comb begin
    stb = '0;
    if (state == ST_IDLE && startValid) stb.load = 1'b1;
    if (tick) begin
      if (!sckLvl) begin
        stb.rise = 1'b1;
        if (!inPre) begin
          stb.sample = 1'b1;
          if (dataBit == 3'd7) stb.present = 1'b1;
        end
      end else begin
        stb.fall = 1'b1;
        if (!inPre && bytesLeft == '0) stb.csRelease = 1'b1;
        else stb.shiftTx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      fastMode  <= 1'b1;
      divCnt    <= '0;
      preLeft   <= '0;
      dataBit   <= '0;
      bytesLeft <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startValid) begin
            fastMode  <= reqFast;
            preLeft   <= reqFast ? 6'(HDR_FAST) : 6'(HDR_SLOW);
            bytesLeft <= reqCount;
            dataBit   <= '0;
            divCnt    <= '0;
            state     <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!stall) divCnt <= tick ? '0 : divCnt + DIV_W'(1);
          if (stb.rise) begin
            if (inPre) preLeft <= preLeft - 6'd1;
            else dataBit <= dataBit + 3'd1;
          end
          if (stb.present) bytesLeft <= bytesLeft - CNT_W'(1);
          if (stb.csRelease) begin
            state  <= ST_GAP;
            divCnt <= '0;
          end
        end
        ST_GAP: begin
          if (divCnt < gapEnd) divCnt <= divCnt + DIV_W'(1);
          else if (!outValid) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sflash_rd_dpath.sv
module sflash_rd_dpath
  import sflash_rd_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int OFF_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic              reqPage264,
  input  logic              reqFast,
  input  logic              miso,
  input  logic              outReady,
  output logic              csN,
  output logic              sck,
  output logic              mosi,
  output logic [7:0]        outData,
  output logic              outValid
);
  localparam int ADDR_W = 24;

  logic [FRAME_W-1:0] txShift;
  logic [7:0]         rxShift;
  logic [ADDR_W-1:0]  addrWide;
  logic [ADDR_W-1:0]  addrLin;
  logic [ADDR_W-1:0]  addrSel;

  // page field sits above the offset; the linear layout drops the top offset bit
  assign addrWide = (ADDR_W'(reqPage) << OFF_W) | ADDR_W'(reqOffset);
  assign addrLin = (ADDR_W'(reqPage) << (OFF_W - 1)) | ADDR_W'(reqOffset[OFF_W-2:0]);
  assign addrSel = reqPage264 ? addrWide : addrLin;
  assign mosi = txShift[FRAME_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN      <= 1'b1;
      sck      <= 1'b0;
      txShift  <= '0;
      rxShift  <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      if (stb.load) begin
        txShift <= {(reqFast ? OP_FAST : OP_SLOW), addrSel, 8'h00};
        csN     <= 1'b0;
        sck     <= 1'b0;
      end
      if (stb.rise) sck <= 1'b1;
      if (stb.fall) sck <= 1'b0;
      if (stb.shiftTx) txShift <= txShift << 1;
      if (stb.csRelease) csN <= 1'b1;
      if (stb.sample) rxShift <= {rxShift[6:0], miso};
      if (stb.present) begin
        outData  <= {rxShift[6:0], miso};
        outValid <= 1'b1;
      end else if (outValid && outReady) begin
        outValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sflash_cont_reader.sv
module sflash_cont_reader
  import sflash_rd_pkg::*;
#(
  parameter int FAST_HALF = 1,
  parameter int PAGE_W = 12,
  parameter int OFF_W = 9,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  output logic              startReady,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              reqPage264,
  input  logic              reqFast,
  output logic              csN,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [7:0]        outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              done
);
  strobe_t stb;

  sflash_rd_ctrl #(.FAST_HALF(FAST_HALF), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .reqCount(reqCount),
    .reqFast(reqFast), .sckLvl(sck), .outValid(outValid),
    .startReady(startReady), .done(done), .stb(stb)
  );

  sflash_rd_dpath #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqPage(reqPage), .reqOffset(reqOffset),
    .reqPage264(reqPage264), .reqFast(reqFast), .miso(miso), .outReady(outReady),
    .csN(csN), .sck(sck), .mosi(mosi), .outData(outData), .outValid(outValid)
  );
endmodule

// File: rtl/sflash_rd_chk.sv
module sflash_rd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startValid,
  input logic       startReady,
  input logic       csN,
  input logic       sck,
  input logic       mosi,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outReady,
  input logic       done
);
  // R6
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN) && sck && $past(sck)) |-> $stable(mosi));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R9
  done_after_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && !outValid));

  // R9
  start_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && startReady) |=> !csN);
endmodule

bind sflash_cont_reader sflash_rd_chk u_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
  .csN(csN), .sck(sck), .mosi(mosi), .outData(outData), .outValid(outValid),
  .outReady(outReady), .done(done)
);

// File: tb/sflash_cont_reader_tb.sv
module sflash_cont_reader_tb;
  localparam int FH = 1;
  localparam int PW = 12;
  localparam int OW = 9;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic startReady;
  logic [PW-1:0] reqPage = '0;
  logic [OW-1:0] reqOffset = '0;
  logic [CW-1:0] reqCount = '0;
  logic reqPage264 = 1'b0;
  logic reqFast = 1'b0;
  logic csN, sck, mosi;
  logic miso = 1'b0;
  logic [7:0] outData;
  logic outValid;
  logic outReady = 1'b0;
  logic done;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  logic [7:0] expQ[$];

  // model and monitor state
  bit cfg264 = 1'b0;
  int nb = 0;
  logic [7:0] capOp = '0;
  logic [23:0] capAd = '0;
  int csFalls = 0;
  int idx = 0;
  int ob = 0;
  int tRise = 0;
  int tCsUp = 0;
  int expHalf = FH;
  int prevHalf = FH;
  bit haveGap = 1'b0;
  int readyMode = 0;
  logic [7:0] lf = 8'hA5;

  sflash_cont_reader #(.FAST_HALF(FH), .PAGE_W(PW), .OFF_W(OW), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .reqPage(reqPage), .reqOffset(reqOffset), .reqCount(reqCount),
    .reqPage264(reqPage264), .reqFast(reqFast), .csN(csN), .sck(sck), .mosi(mosi),
    .miso(miso), .outData(outData), .outValid(outValid), .outReady(outReady), .done(done)
  );

  always #5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] memByte(input int i);
    int t;
    t = (i * 37) ^ (i >>> 8) ^ (i >>> 16);
    return t[7:0];
  endfunction

  function automatic int arrSize(input bit m264);
    return m264 ? 4096 * 264 : (1 << 20);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  // flash model: header capture on rising SCK
  always @(negedge csN or posedge sck) begin
    if (!sck) begin
      nb = 0;
      csFalls = csFalls + 1;
    end else if (!csN) begin
      if (nb < 8) capOp = {capOp[6:0], mosi};
      else if (nb < 32) capAd = {capAd[22:0], mosi};
      nb = nb + 1;
    end
  end

  // flash model: data driven on falling SCK, auto-increment with wrap
  always @(negedge sck) begin
    int hl;
    logic [7:0] b;
    hl = (capOp == 8'h0B) ? 40 : 32;
    if (!csN && nb >= hl) begin
      if (nb == hl) begin
        ob = 0;
        if (cfg264) idx = int'(capAd[20:9]) * 264 + int'(capAd[8:0]);
        else idx = int'(capAd[19:0]);
      end
      b = memByte(idx);
      miso = b[7-ob];
      ob = ob + 1;
      if (ob == 8) begin
        ob = 0;
        idx = (idx + 1) % arrSize(cfg264);
      end
    end
  end

  // R7: every SCK high phase has the width set by the command speed
  always @(posedge sck) tRise = cyc;
  always @(negedge sck) if (rstN) chk((cyc - tRise) == expHalf, "R7", "sck high width", cyc - tRise, expHalf);

  // R10: chip select idle time between requests
  always @(posedge csN) tCsUp = cyc;
  always @(negedge csN) if (haveGap) chk((cyc - tCsUp) >= 2 * prevHalf, "R10", "cs high gap", cyc - tCsUp, 2 * prevHalf);

  // consumer ready pattern
  initial begin
    forever begin
      @(posedge clk);
      #2;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      case (readyMode)
        0: outReady = 1'b1;
        1: outReady = lf[0];
        default: outReady = ((cyc % 97) == 0);
      endcase
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) chk(1'b0, "R8", "unexpected byte", outData, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        chk(outData == e, "R8", "stream byte", outData, e);
      end
    end
  end

  task automatic runReq(input int page, input int off, input int cnt, input bit m264, input bit fast, input int rmode);
    logic [23:0] expAd;
    logic [7:0] expOp;
    int idx0;
    int f0;
    cfg264 = m264;
    readyMode = rmode;
    expHalf = fast ? FH : 2 * FH;
    expOp = fast ? 8'h0B : 8'h03;
    if (m264) begin
      expAd = {3'b000, 12'(page), 9'(off)};
      idx0 = page * 264 + off;
    end else begin
      expAd = {4'b0000, 12'(page), 8'(off)};
      idx0 = page * 256 + (off % 256);
    end
    for (int k = 0; k < cnt; k++) expQ.push_back(memByte((idx0 + k) % arrSize(m264)));
    @(posedge clk);
    #2;
    wait (startReady);
    chk(startReady == 1'b1, "R9", "ready before start", startReady, 1);
    f0 = csFalls;
    startValid = 1'b1;
    reqPage = PW'(page);
    reqOffset = OW'(off);
    reqCount = CW'(cnt);
    reqPage264 = m264;
    reqFast = fast;
    @(posedge clk);
    #2;
    startValid = 1'b0;
    chk(startReady == 1'b0, "R9", "busy after start", startReady, 0);
    do @(negedge clk); while (!done);
    chk(csN == 1'b1, "R9", "cs high at done", csN, 1);
    chk(expQ.size() == 0, "R9", "bytes left at done", expQ.size(), 0);
    if (fast) chk(capOp == expOp, "R1", "fast opcode", capOp, expOp);
    else chk(capOp == expOp, "R2", "slow opcode", capOp, expOp);
    if (m264) chk(capAd == expAd, "R3", "page/offset address", capAd, expAd);
    else chk(capAd == expAd, "R4", "linear address", capAd, expAd);
    chk((csFalls - f0) == 1, "R5", "single cs low span", csFalls - f0, 1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", done, 0);
    haveGap = 1'b1;
    prevHalf = expHalf;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R6 R9 reset state
    chk(csN == 1'b1, "R9", "reset csN", csN, 1);
    chk(sck == 1'b0, "R6", "reset sck", sck, 0);
    chk(outValid == 1'b0, "R8", "reset outValid", outValid, 0);
    chk(startReady == 1'b1, "R9", "reset startReady", startReady, 1);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    runReq(3, 10, 6, 1'b1, 1'b1, 0);        // R1 R3 fast, 264 layout
    runReq(5, 262, 5, 1'b1, 1'b0, 1);       // R2 R5 page crossing, random ready
    runReq(12'h123, 9'h1FF, 4, 1'b0, 1'b1, 0); // R4 offset bit 8 ignored
    runReq(4095, 261, 6, 1'b1, 1'b0, 0);    // R5 wrap at end of array, 264 layout
    runReq(4095, 253, 5, 1'b0, 1'b1, 1);    // R5 wrap at end of array, 256 layout
    runReq(7, 0, 3, 1'b0, 1'b0, 2);         // R8 long consumer stalls
    runReq(100, 40, 9, 1'b1, 1'b1, 1);      // R10 back-to-back with the stalled slow read
    repeat (5) @(posedge clk);
    summary();
    $finish;
  end
endmodule